// File: doc/BRIEF.md
# Rank-Based Parallel Merger

This block merges two arrays that are each already in ascending order, both of the same length N, into one ascending array of 2N elements in a single combinational pass. Nothing steps or iterates from one clock to the next. Each element works out its own final position: its index within its source array, plus the number of elements of the opposite array that must precede it. A bank of signed magnitude comparators produces these counts in parallel. An AND-OR network then routes each element to the output slot whose number matches its rank.

Element width, array length and an optional output register are parameters. With the register disabled, the output follows the inputs combinationally. With it enabled, the output lags the inputs by one clock and has a synchronous active-high clear.

Top module: `rank_merge`

## Requirements
- R1: Parameters W (element width, default 8), N (elements per input, default 5) and REG_OUT (default 0) set the shape. Element e of any packed port occupies bits [e*W +: W], and element 0 is the smallest.
- R2: The 2N output elements are in non-decreasing signed order and are exactly the union of both inputs, with duplicates kept.
- R3: Ties go to A first. An A element is placed at its index plus the count of B elements strictly below it. A B element is placed at its index plus the count of A elements less than or equal to it. Because of this rule, every output slot receives exactly one source element, even when values repeat across the arrays.
- R4: Values are compared as two's-complement signed numbers, including the most negative and most positive codes. Output element 0 is the smaller of the two input heads, and output element 2N-1 is the larger of the two input tails.
- R5: With REG_OUT=0 the output depends only on the current inputs, in the same cycle, and clock and reset have no effect on it.
- R6: With REG_OUT=1, a clock edge with rst high sets every output bit to zero.
- R7: With REG_OUT=1 and rst low, each clock edge loads the merge of the inputs present at that edge, so the output lags the inputs by one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register and for the assertions |
| rst | input | 1 | Synchronous active-high clear of the output register |
| a_in | input | N*W | First sorted array, element e at [e*W +: W] |
| b_in | input | N*W | Second sorted array, same layout |
| merged_out | output | 2*N*W | Merged ascending array, element k at [k*W +: W] |

## Verification
The assertions check four things on every cycle:
- each output slot has exactly one contributing source;
- neighbouring output elements are in ascending order;
- the two end slots equal the minimum head and the maximum tail;
- in registered mode, the clear and the one-cycle lag both hold.

Two things can only be shown by the bench's scenarios. The first is that the output holds exactly the right values: a wrong rank can still produce an ordered but incorrect array. The second is that the signed extremes and long runs of ties come out right. An exhaustive sweep over every pair of sorted three-element arrays of 3-bit values does this, compared against a two-pointer reference merge. Directed cases at the default size add further coverage.

// File: rtl/rank_merge.sv
module rank_merge #(
  parameter int W = 8,
  parameter int N = 5,
  parameter bit REG_OUT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N*W-1:0]   a_in,
  input  logic [N*W-1:0]   b_in,
  output logic [2*N*W-1:0] merged_out
);

  localparam int M  = 2 * N;
  localparam int RW = $clog2(M);

  logic signed [W-1:0] a_e  [N];
  logic signed [W-1:0] b_e  [N];
  logic signed [W-1:0] cand [M];
  logic [RW-1:0]       rank [M];
  logic [M-1:0]        hit  [M];
  logic [M*W-1:0]      merged_c;

  for (genvar i = 0; i < N; i++) begin : g_unpack
    assign a_e[i]      = a_in[i*W +: W];
    assign b_e[i]      = b_in[i*W +: W];
    assign cand[i]     = a_e[i];
    assign cand[N + i] = b_e[i];
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      rank[i]     = RW'(i);
      rank[N + i] = RW'(i);
      for (int j = 0; j < N; j++) begin
        if (b_e[j] <  a_e[i]) rank[i]     = rank[i] + 1'b1;
        if (a_e[j] <= b_e[i]) rank[N + i] = rank[N + i] + 1'b1;
      end
    end
    merged_c = '0;
    for (int k = 0; k < M; k++) begin
      for (int c = 0; c < M; c++) begin
        hit[k][c] = (rank[c] == RW'(k));
        merged_c[k*W +: W] = merged_c[k*W +: W] | (cand[c] & {W{hit[k][c]}});
      end
    end
  end

  if (REG_OUT) begin : g_reg
    logic [M*W-1:0] merged_q;
    always_ff @(posedge clk) begin
      if (rst) merged_q <= '0;
      else     merged_q <= merged_c;
    end
    assign merged_out = merged_q;

    a_r6_sync_clear: assert property (@(posedge clk) rst |=> merged_out == '0);
    a_r7_one_cycle_lag: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> merged_out == $past(merged_c));
  end else begin : g_comb
    assign merged_out = merged_c;
  end

  for (genvar k = 0; k < M; k++) begin : g_chk
    a_r3_single_source: assert property (@(posedge clk) disable iff (rst)
      $countones(hit[k]) == 1);
    if (k < M - 1) begin : g_ord
      a_r2_ascending: assert property (@(posedge clk) disable iff (rst)
        $signed(merged_c[k*W +: W]) <= $signed(merged_c[(k+1)*W +: W]));
    end
  end

  a_r4_head_min: assert property (@(posedge clk) disable iff (rst)
    $signed(merged_c[0 +: W]) == ((a_e[0] <= b_e[0]) ? a_e[0] : b_e[0]));
  a_r4_tail_max: assert property (@(posedge clk) disable iff (rst)
    $signed(merged_c[(M-1)*W +: W]) == ((a_e[N-1] >= b_e[N-1]) ? a_e[N-1] : b_e[N-1]));

endmodule

// File: tb/test_rank_merge.sv
`timescale 1ns/1ps
module test_rank_merge;
  localparam int SW = 3, SN = 3, BW = 8, BN = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [SN*SW-1:0]   sa, sb;
  logic [2*SN*SW-1:0] so_c, so_r;
  logic [BN*BW-1:0]   ba, bb;
  logic [2*BN*BW-1:0] bo;

  int n_chk = 0;
  int n_fail = 0;

  rank_merge #(.W(SW), .N(SN), .REG_OUT(1'b0)) i_rank_merge (
    .clk(clk), .rst(rst), .a_in(sa), .b_in(sb), .merged_out(so_c));
  rank_merge #(.W(SW), .N(SN), .REG_OUT(1'b1)) i_rank_merge_reg (
    .clk(clk), .rst(rst), .a_in(sa), .b_in(sb), .merged_out(so_r));
  rank_merge #(.W(BW), .N(BN), .REG_OUT(1'b0)) i_rank_merge_big (
    .clk(clk), .rst(rst), .a_in(ba), .b_in(bb), .merged_out(bo));

  task automatic chk(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  function automatic void ref_merge(input int a[BN], input int b[BN], input int n,
                                    output int o[2*BN]);
    int ia = 0, ib = 0;
    for (int k = 0; k < 2*n; k++) begin
      if (ib == n || (ia < n && a[ia] <= b[ib])) begin o[k] = a[ia]; ia++; end
      else begin o[k] = b[ib]; ib++; end
    end
  endfunction

  function automatic int sel_s(input logic [2*SN*SW-1:0] v, input int k);
    logic signed [SW-1:0] e;
    e = v[k*SW +: SW];
    return int'(e);
  endfunction

  function automatic int sel_b(input logic [2*BN*BW-1:0] v, input int k);
    logic signed [BW-1:0] e;
    e = v[k*BW +: BW];
    return int'(e);
  endfunction

  task automatic run_big(input int a[BN], input int b[BN], input string req);
    int o[2*BN];
    for (int e = 0; e < BN; e++) begin
      ba[e*BW +: BW] = BW'(a[e]);
      bb[e*BW +: BW] = BW'(b[e]);
    end
    ref_merge(a, b, BN, o);
    #1;
    for (int k = 0; k < 2*BN; k++) chk(req, sel_b(bo, k), o[k]);
  endtask

  task automatic sort5(inout int v[BN]);
    for (int i = 1; i < BN; i++)
      for (int j = i; j > 0 && v[j-1] > v[j]; j--) begin
        int t = v[j]; v[j] = v[j-1]; v[j-1] = t;
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int lst[120][SN];
    int cnt = 0;
    int a[BN], b[BN], o[2*BN];
    for (int x0 = -4; x0 <= 3; x0++)
      for (int x1 = x0; x1 <= 3; x1++)
        for (int x2 = x1; x2 <= 3; x2++) begin
          lst[cnt][0] = x0; lst[cnt][1] = x1; lst[cnt][2] = x2; cnt++;
        end

    sa = '1; sb = '1; ba = '0; bb = '0;
    repeat (2) @(negedge clk);
    for (int k = 0; k < 2*SN; k++) chk("R6 reset clear", sel_s(so_r, k), 0);
    chk("R5 comb ignores reset", sel_s(so_c, 0), -1);
    rst = 1'b0;

    for (int p = 0; p < cnt; p++)
      for (int q = 0; q < cnt; q++) begin
        @(negedge clk);
        for (int e = 0; e < BN; e++) begin a[e] = 0; b[e] = 0; end
        for (int e = 0; e < SN; e++) begin
          a[e] = lst[p][e]; b[e] = lst[q][e];
          sa[e*SW +: SW] = SW'(lst[p][e]);
          sb[e*SW +: SW] = SW'(lst[q][e]);
        end
        ref_merge(a, b, SN, o);
        #1;
        for (int k = 0; k < 2*SN; k++) chk("R2 R3 R4 R5 comb merge", sel_s(so_c, k), o[k]);
        @(negedge clk);
        for (int k = 0; k < 2*SN; k++) chk("R7 registered merge", sel_s(so_r, k), o[k]);
      end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 2*SN; k++) chk("R6 mid-run clear", sel_s(so_r, k), 0);
    chk("R5 comb output unaffected by reset", sel_s(so_c, 2*SN-1), o[2*SN-1]);
    rst = 1'b0;

    a = '{7, 7, 7, 7, 7};            b = '{7, 7, 7, 7, 7};            run_big(a, b, "R3 all equal");
    a = '{-9, -5, -1, 3, 7};         b = '{-7, -3, 1, 5, 9};          run_big(a, b, "R2 interleaved");
    a = '{-50, -40, -30, -20, -10};  b = '{10, 20, 30, 40, 50};       run_big(a, b, "R2 A below B");
    a = '{10, 20, 30, 40, 50};       b = '{-50, -40, -30, -20, -10};  run_big(a, b, "R2 B below A");
    a = '{-128, -128, 0, 127, 127};  b = '{-128, -1, 0, 1, 127};      run_big(a, b, "R4 signed extremes");
    a = '{1, 2, 2, 2, 3};            b = '{2, 2, 2, 2, 2};            run_big(a, b, "R3 tie runs");
    for (int r = 0; r < 40; r++) begin
      for (int e = 0; e < BN; e++) begin
        a[e] = int'($urandom_range(255)) - 128;
        b[e] = int'($urandom_range(255)) - 128;
      end
      sort5(a); sort5(b);
      run_big(a, b, "R1 default-size random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule